// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning and Reset Request

This block is a watchdog peripheral on a simple word-wide register bus. One counter advances by one on every clock while the watchdog is armed. Two limits are compared against that single count. The lower limit, the warning threshold, raises an interrupt level so software gets a last chance to service the timer. The upper limit, the reset threshold, produces a one-cycle request to the system reset controller. Both limits are given in clock ticks.

Software services the timer by writing a one to the restart register, which returns the count to zero. The usual arming sequence is as follows. Software disarms the timer, restarts it, loads the warning limit a little below the reset limit, and then arms it again. Loading limits while the timer is disarmed never produces a warning or a reset request. A status register shows both flags and the live count. Reading it changes nothing.

Top module: `wdtBarkBite`

## Requirements
- R1: After reset, the enable bit reads 0, both limits read 0, the count is 0, and `barkIrq` and `biteReq` are low.
- R2: The byte offsets are restart 0x04, enable 0x08, status 0x0C, warning limit 0x10 and reset limit 0x14. Each limit register holds the low CNT_W bits of a write and reads them back zero-extended.
- R3: The enable register keeps bit 0 of the last write and reads back as that bit with all other bits zero.
- R4: While enabled, the count rises by one per clock. While disabled, it holds its value.
- R5: A write to the restart offset with bit 0 set clears the count on that clock edge. A write there with bit 0 clear has no effect. The restart offset reads as zero.
- R6: The count stops at the reset limit and stays there until a restart.
- R7: `barkIrq` is high exactly while the watchdog is enabled and count >= warning limit. Both a restart and a disable drop it.
- R8: `biteReq` is high for exactly one cycle, the first cycle in which the watchdog is enabled and count >= reset limit. It fires only once between restarts.
- R9: The status register holds `barkIrq` in bit 0, the reset-reached flag (enabled and count >= reset limit) in bit 1, and the count in bits CNT_W+1 down to 2. All other bits read zero.
- R10: Reads from any offset not listed in R2, including unaligned ones, return zero. Writes to those offsets change no state.
- R11: Writing either limit while disabled raises neither `barkIrq` nor `biteReq`.
- R12: Reads have no side effects. Repeated reads of status with no clock-advancing events in between return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count tick |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| barkIrq | output | 1 | Early-warning interrupt level |
| biteReq | output | 1 | One-cycle system reset request |

## Verification
Read data is combinational from `addr`, so the bench samples it 1 ns after it changes the address at a falling edge, with no clock edge in between. A write takes effect on the single rising edge inside the write task. After an enable write the count is 0, and it equals N after N further rising edges. Both output flags are combinational on the registered count. So `barkIrq` is due after the edge that brings the count to the warning limit, and `biteReq` is due in the cycle that follows the edge bringing the count to the reset limit and is gone one edge later. The bench therefore samples every output at the falling edge that follows the edge which should change it.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  // Register byte offsets; software depends on these positions.
  localparam int OFF_RESTART = 'h04;
  localparam int OFF_ENABLE  = 'h08;
  localparam int OFF_STATUS  = 'h0C;
  localparam int OFF_BARK    = 'h10;
  localparam int OFF_BITE    = 'h14;

  // Decoded write strobes passed from control to datapath.
  typedef struct packed {
    logic restart;
    logic enWr;
    logic barkWr;
    logic biteWr;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic              enR,
  input  logic [CNT_W-1:0]  barkTh,
  input  logic [CNT_W-1:0]  biteTh,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              barkIrq,
  input  logic              biteHit,
  output wdtStrobe_t        stb,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFF_RESTART);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_BARK    = ADDR_W'(OFF_BARK);
  localparam logic [ADDR_W-1:0] A_BITE    = ADDR_W'(OFF_BITE);

  // Write decode: anything not matching a mapped offset yields no strobe.
  always_comb begin
    stb         = '0;
    stb.restart = wrEn && (addr == A_RESTART) && wrBit0;
    stb.enWr    = wrEn && (addr == A_ENABLE);
    stb.barkWr  = wrEn && (addr == A_BARK);
    stb.biteWr  = wrEn && (addr == A_BITE);
  end

  // Read mux: side-effect free, unmapped offsets return zero.
  always_comb begin
    rdData = '0;
    unique case (addr)
      A_ENABLE: rdData[0] = enR;
      A_STATUS: begin
        rdData[0]         = barkIrq;
        rdData[1]         = biteHit;
        rdData[CNT_W+1:2] = cnt;
      end
      A_BARK:   rdData[CNT_W-1:0] = barkTh;
      A_BITE:   rdData[CNT_W-1:0] = biteTh;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/wdt_datapath.sv
`timescale 1ns/1ps
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       stb,
  input  logic [CNT_W-1:0] wrVal,
  output logic             enR,
  output logic [CNT_W-1:0] barkTh,
  output logic [CNT_W-1:0] biteTh,
  output logic [CNT_W-1:0] cnt,
  output logic             barkIrq,
  output logic             biteHit,
  output logic             biteReq
);

  logic biteSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enR      <= 1'b0;
      barkTh   <= '0;
      biteTh   <= '0;
      cnt      <= '0;
      biteSeen <= 1'b0;
    end else begin
      if (stb.enWr)   enR    <= wrVal[0];
      if (stb.barkWr) barkTh <= wrVal;
      if (stb.biteWr) biteTh <= wrVal;

      if (stb.restart)               cnt <= '0;
      else if (enR && cnt < biteTh)  cnt <= cnt + CNT_W'(1);

      if (stb.restart)      biteSeen <= 1'b0;
      else if (biteReq)     biteSeen <= 1'b1;
    end
  end

  assign barkIrq = enR && (cnt >= barkTh);
  assign biteHit = enR && (cnt >= biteTh);
  assign biteReq = biteHit && !biteSeen;

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enR && !stb.restart && cnt < biteTh) |=> cnt == $past(cnt) + CNT_W'(1));

  // R5
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> cnt == '0);

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.restart && cnt >= biteTh) |=> $stable(cnt));

  // R8
  bite_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (biteReq && !stb.restart) |=> !biteReq);

  // R7
  bark_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enWr && !wrVal[0]) |=> !barkIrq);

endmodule

// File: rtl/wdtBarkBite.sv
`timescale 1ns/1ps
module wdtBarkBite
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              barkIrq,
  output logic              biteReq
);

  localparam int DATA_W = 32;

  wdtStrobe_t       stb;
  logic             enR;
  logic             biteHit;
  logic [CNT_W-1:0] barkTh;
  logic [CNT_W-1:0] biteTh;
  logic [CNT_W-1:0] cnt;
  logic             unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:CNT_W];

  wdt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .wrBit0  (wrData[0]),
    .enR     (enR),
    .barkTh  (barkTh),
    .biteTh  (biteTh),
    .cnt     (cnt),
    .barkIrq (barkIrq),
    .biteHit (biteHit),
    .stb     (stb),
    .rdData  (rdData)
  );

  wdt_datapath #(.CNT_W(CNT_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrVal   (wrData[CNT_W-1:0]),
    .enR     (enR),
    .barkTh  (barkTh),
    .biteTh  (biteTh),
    .cnt     (cnt),
    .barkIrq (barkIrq),
    .biteHit (biteHit),
    .biteReq (biteReq)
  );

endmodule

// File: tb/tb_wdtBarkBite.sv
`timescale 1ns/1ps
module tb_wdtBarkBite;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        barkIrq;
  logic        biteReq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdtBarkBite #(.ADDR_W(5), .CNT_W(20)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .barkIrq(barkIrq), .biteReq(biteReq)
  );

  localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPI = 2'd2, OPO = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [1:0]  outs;   // {barkIrq, biteReq}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 55;
  localparam vec_t VECS [NV] = '{
    '{OPR, 5'h08, 32'd0,  2'b00, 4'd1},   // R1
    '{OPR, 5'h10, 32'd0,  2'b00, 4'd1},   // R1
    '{OPR, 5'h14, 32'd0,  2'b00, 4'd1},   // R1
    '{OPR, 5'h0C, 32'd0,  2'b00, 4'd1},   // R1
    '{OPO, 5'h00, 32'd0,  2'b00, 4'd1},   // R1
    '{OPW, 5'h10, 32'd5,  2'b00, 4'd2},   // R2
    '{OPW, 5'h14, 32'd8,  2'b00, 4'd2},   // R2
    '{OPO, 5'h00, 32'd0,  2'b00, 4'd11},  // R11
    '{OPR, 5'h10, 32'd5,  2'b00, 4'd2},   // R2
    '{OPR, 5'h14, 32'd8,  2'b00, 4'd2},   // R2
    '{OPR, 5'h04, 32'd0,  2'b00, 4'd5},   // R5
    '{OPW, 5'h04, 32'd1,  2'b00, 4'd5},   // R5
    '{OPW, 5'h08, 32'd1,  2'b00, 4'd3},   // R3
    '{OPR, 5'h08, 32'd1,  2'b00, 4'd3},   // R3
    '{OPR, 5'h0C, 32'd0,  2'b00, 4'd9},   // R9
    '{OPI, 5'h00, 32'd3,  2'b00, 4'd4},   // R4
    '{OPR, 5'h0C, 32'd12, 2'b00, 4'd4},   // R4
    '{OPO, 5'h00, 32'd0,  2'b00, 4'd7},   // R7
    '{OPI, 5'h00, 32'd2,  2'b00, 4'd4},   // R4
    '{OPR, 5'h0C, 32'd21, 2'b00, 4'd9},   // R9
    '{OPO, 5'h00, 32'd0,  2'b10, 4'd7},   // R7
    '{OPI, 5'h00, 32'd3,  2'b00, 4'd4},   // R4
    '{OPR, 5'h0C, 32'd35, 2'b00, 4'd9},   // R9
    '{OPO, 5'h00, 32'd0,  2'b11, 4'd8},   // R8
    '{OPI, 5'h00, 32'd1,  2'b00, 4'd6},   // R6
    '{OPO, 5'h00, 32'd0,  2'b10, 4'd8},   // R8
    '{OPR, 5'h0C, 32'd35, 2'b00, 4'd6},   // R6
    '{OPI, 5'h00, 32'd4,  2'b00, 4'd6},   // R6
    '{OPR, 5'h0C, 32'd35, 2'b00, 4'd6},   // R6
    '{OPW, 5'h04, 32'd0,  2'b00, 4'd5},   // R5
    '{OPR, 5'h0C, 32'd35, 2'b00, 4'd5},   // R5
    '{OPW, 5'h04, 32'd1,  2'b00, 4'd5},   // R5
    '{OPR, 5'h0C, 32'd0,  2'b00, 4'd5},   // R5
    '{OPO, 5'h00, 32'd0,  2'b00, 4'd7},   // R7
    '{OPW, 5'h08, 32'd0,  2'b00, 4'd3},   // R3
    '{OPR, 5'h08, 32'd0,  2'b00, 4'd3},   // R3
    '{OPR, 5'h0C, 32'd4,  2'b00, 4'd4},   // R4
    '{OPI, 5'h00, 32'd5,  2'b00, 4'd4},   // R4
    '{OPR, 5'h0C, 32'd4,  2'b00, 4'd4},   // R4
    '{OPR, 5'h0C, 32'd4,  2'b00, 4'd12},  // R12
    '{OPW, 5'h00, 32'hFFFF_FFFF, 2'b00, 4'd10}, // R10
    '{OPW, 5'h18, 32'hFFFF_FFFF, 2'b00, 4'd10}, // R10
    '{OPW, 5'h05, 32'd1,  2'b00, 4'd10},  // R10
    '{OPR, 5'h00, 32'd0,  2'b00, 4'd10},  // R10
    '{OPR, 5'h18, 32'd0,  2'b00, 4'd10},  // R10
    '{OPR, 5'h1C, 32'd0,  2'b00, 4'd10},  // R10
    '{OPR, 5'h05, 32'd0,  2'b00, 4'd10},  // R10
    '{OPR, 5'h0C, 32'd4,  2'b00, 4'd10},  // R10
    '{OPR, 5'h08, 32'd0,  2'b00, 4'd10},  // R10
    '{OPR, 5'h10, 32'd5,  2'b00, 4'd10},  // R10
    '{OPR, 5'h14, 32'd8,  2'b00, 4'd10},  // R10
    '{OPW, 5'h10, 32'd0,  2'b00, 4'd11},  // R11
    '{OPW, 5'h14, 32'd0,  2'b00, 4'd11},  // R11
    '{OPO, 5'h00, 32'd0,  2'b00, 4'd11},  // R11
    '{OPR, 5'h0C, 32'd4,  2'b00, 4'd11}   // R11
  };

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkRd(input logic [4:0] a, input logic [31:0] exp, input int req);
    addr = a;
    #1;
    tests++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL R%0d read %h: got %h expected %h", req, a, rdData, exp);
    end
  endtask

  task automatic chkOut(input logic [1:0] exp, input int req);
    #1;
    tests++;
    if ({barkIrq, biteReq} !== exp) begin
      fails++;
      $display("FAIL R%0d outputs {bark,bite}: got %b expected %b", req, {barkIrq, biteReq}, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int biteCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OPW: wr(VECS[i].addr, VECS[i].data);
        OPR: chkRd(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
        OPI: repeat (int'(VECS[i].data)) @(negedge clk);
        default: chkOut(VECS[i].outs, int'(VECS[i].req));
      endcase
    end

    // R8 / R7: warning at 2, reset request at 3, exactly one pulse
    @(negedge clk);
    wr(5'h10, 32'd2);
    wr(5'h14, 32'd3);
    wr(5'h04, 32'd1);
    wr(5'h08, 32'd1);
    biteCnt = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chkOut({(k >= 2), (k == 3)}, 8);   // R8 timing, R7 level
      if (biteReq) biteCnt++;
    end
    tests++;
    if (biteCnt != 1) begin
      fails++;
      $display("FAIL R8 pulse count: got %0d expected 1", biteCnt);
    end

    // R7: restart drops the warning; R8: fires again after restart
    wr(5'h04, 32'd1);
    chkOut(2'b00, 7);                    // R7
    repeat (3) @(negedge clk);
    chkOut(2'b11, 8);                    // R8

    // R7: disable drops the warning
    wr(5'h08, 32'd0);
    chkOut(2'b00, 7);                    // R7

    // R1: reset in the middle of a run
    wr(5'h08, 32'd1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chkRd(5'h08, 32'd0, 1);              // R1
    chkRd(5'h10, 32'd0, 1);              // R1
    chkRd(5'h14, 32'd0, 1);              // R1
    chkRd(5'h0C, 32'd0, 1);              // R1
    chkOut(2'b00, 1);                    // R1

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule